// File: doc/BRIEF.md
# Numerically Tuned Quadrature Upconverter

This block moves an interpolated complex baseband stream up to a programmable carrier and produces one real, signed 12-bit sample per enabled clock. A phase accumulator clocked at the system sample rate advances by a tuning word on every enabled cycle. The top bits of the phase address a folded quarter-wave sine table, which gives a cosine and a sine a quarter turn apart. These scale the in-phase and quadrature inputs. The difference of the two products is rounded and clamped to the output width.

It sits between the interpolation filters and the converter. The carrier frequency is `ftw / 2^32` times the sample rate. It is only usable up to about thirty percent of that rate. A clock enable stalls the whole datapath, including the oscillator, so a gated or bursty sample rate keeps phase continuity.

Top module: `quad_upconv`

## Requirements
- R1: The 32-bit phase accumulator is cleared by reset. Each enabled cycle adds `ftw` to it modulo 2^32. The phase used for a sample is the accumulator value before that cycle's addition.
- R2: The table address is the top 10 bits of the phase, `p`. The sine is `round(2047*sin(2*pi*(p+0.5)/1024))` as a 12-bit signed value.
- R3: The cosine uses the same formula with cos in place of sin, so it leads the sine by exactly 256 address steps.
- R4: The output is `floor((I*cos - Q*sin + 1024) / 2048)`. I, Q, cos and sin are the signed values of one sample.
- R5: Results above 2047 are clamped to 2047, and results below -2048 are clamped to -2048.
- R6: A sample presented on an enabled cycle appears on `mod_out` after the third enabled rising edge, counting the edge that captures it.
- R7: While `en` is low, `mod_out` and the phase hold, and `i_in`, `q_in` and `ftw` are ignored.
- R8: A changed `ftw` is used by the next enabled edge, and the phase already accumulated is not cleared.
- R9: Synchronous active-high `rst` clears the accumulator and every pipeline stage, so `mod_out` reads 0 after reset.
- R10: `i_in` and `q_in` are two's-complement 12-bit signed values, with -2048 allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for the accumulator and all stages |
| ftw | input | 32 | Frequency tuning word |
| i_in | input | 12 | In-phase baseband sample, signed |
| q_in | input | 12 | Quadrature baseband sample, signed |
| mod_out | output | 12 | Modulated real carrier sample, signed |

## Verification
The hardest case to reach is clamping, in both directions. It needs full-scale inputs of opposite sign that line up with table phases near 45 and 225 degrees. The bench reaches it by stepping the phase one table address per cycle with `ftw = 2^22` while holding I at -2048 and Q at 2047. This visits every address with both extreme products. Enable gaps with changing inputs and tuning words placed inside those gaps show that a stalled cycle consumes nothing.

// File: rtl/upconv_pkg.sv
package upconv_pkg;

    localparam int PHASE_W = 32;
    localparam int ADDR_W  = 10;
    localparam int SAMP_W  = 12;
    localparam int TRIG_W  = 12;
    localparam int OUT_W   = 12;

    // Which quarter of the carrier period a table address falls in
    typedef enum logic [1:0] {
        QD_RISE = 2'd0,
        QD_PEAK = 2'd1,
        QD_FALL = 2'd2,
        QD_TROUGH = 2'd3
    } quad_e;

    // Round half up at bit 'frac', then clamp to a signed 'outw'-bit range
    function automatic longint round_clamp(input longint v, input int frac, input int outw);
        longint r;
        longint hi;
        longint lo;
        r  = (v + (longint'(1) <<< (frac - 1))) >>> frac;
        hi = (longint'(1) <<< (outw - 1)) - 1;
        lo = -hi - 1;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int PHASE_W = upconv_pkg::PHASE_W,
    parameter int ADDR_W  = upconv_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw,
    output logic [ADDR_W-1:0]  phase_addr
);
    logic [PHASE_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (en) acc <= acc + ftw;
    end

    assign phase_addr = acc[PHASE_W-1 -: ADDR_W];

    // R7
    acc_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

    // R1
    acc_zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && ftw == '0) |=> $stable(acc));

endmodule

// File: rtl/sincos_lut.sv
module sincos_lut #(
    parameter int ADDR_W = upconv_pkg::ADDR_W,
    parameter int AMP_W  = upconv_pkg::TRIG_W
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    import upconv_pkg::*;

    localparam int QN    = 2 ** (ADDR_W - 2);
    localparam int IDX_W = ADDR_W - 2;
    localparam int PEAK  = 2 ** (AMP_W - 1) - 1;

    function automatic int quarter_val(input int k);
        real ang;
        ang = 3.14159265358979323846 * (real'(k) + 0.5) / (2.0 * real'(QN));
        return int'(real'(PEAK) * $sin(ang));
    endfunction

    logic signed [AMP_W-1:0] qtab [QN];

    for (genvar k = 0; k < QN; k++) begin : g_qtab
        assign qtab[k] = AMP_W'(quarter_val(k));
    end

    function automatic logic signed [AMP_W-1:0] fold(input logic [ADDR_W-1:0] a);
        quad_e             qd;
        logic [IDX_W-1:0]  idx;
        logic signed [AMP_W-1:0] mag;
        qd  = quad_e'(a[ADDR_W-1 -: 2]);
        idx = a[IDX_W-1:0];
        if (qd == QD_PEAK || qd == QD_TROUGH) idx = ~idx;
        mag = qtab[idx];
        return (qd == QD_FALL || qd == QD_TROUGH) ? -mag : mag;
    endfunction

    logic [ADDR_W-1:0] cos_addr;

    always_comb begin
        cos_addr = addr + ADDR_W'(QN);
        sin_o    = fold(addr);
        cos_o    = fold(cos_addr);
    end

endmodule

// File: rtl/mix_core.sv
module mix_core #(
    parameter int SAMP_W = upconv_pkg::SAMP_W,
    parameter int TRIG_W = upconv_pkg::TRIG_W,
    parameter int OUT_W  = upconv_pkg::OUT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [SAMP_W-1:0] i_s,
    input  logic signed [SAMP_W-1:0] q_s,
    input  logic signed [TRIG_W-1:0] cos_s,
    input  logic signed [TRIG_W-1:0] sin_s,
    output logic signed [OUT_W-1:0]  mix_out
);
    import upconv_pkg::*;

    localparam int PROD_W = SAMP_W + TRIG_W;
    localparam int DIFF_W = PROD_W + 1;
    localparam int FRAC   = TRIG_W - 1;

    logic signed [PROD_W-1:0] prod_i;
    logic signed [PROD_W-1:0] prod_q;
    logic signed [DIFF_W-1:0] diff;
    logic signed [OUT_W-1:0]  out_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_i <= '0;
            prod_q <= '0;
        end else if (en) begin
            prod_i <= PROD_W'(i_s) * PROD_W'(cos_s);
            prod_q <= PROD_W'(q_s) * PROD_W'(sin_s);
        end
    end

    always_comb begin
        diff  = DIFF_W'(prod_i) - DIFF_W'(prod_q);
        out_n = OUT_W'(round_clamp(longint'(diff), FRAC, OUT_W));
    end

    always_ff @(posedge clk) begin
        if (rst)     mix_out <= '0;
        else if (en) mix_out <= out_n;
    end

    // R4
    zero_prod_out_chk: assert property (@(posedge clk) disable iff (rst)
        (en && prod_i == '0 && prod_q == '0) |=> (mix_out == '0));

endmodule

// File: rtl/quad_upconv.sv
module quad_upconv #(
    parameter int PHASE_W = upconv_pkg::PHASE_W,
    parameter int ADDR_W  = upconv_pkg::ADDR_W,
    parameter int SAMP_W  = upconv_pkg::SAMP_W,
    parameter int TRIG_W  = upconv_pkg::TRIG_W,
    parameter int OUT_W   = upconv_pkg::OUT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw,
    input  logic [SAMP_W-1:0]  i_in,
    input  logic [SAMP_W-1:0]  q_in,
    output logic [OUT_W-1:0]   mod_out
);
    localparam int PEAK    = 2 ** (TRIG_W - 1) - 1;
    localparam int CIRCLE  = PEAK * PEAK;
    localparam int CIR_TOL = 2 * PEAK + 8;

    typedef struct packed {
        logic signed [SAMP_W-1:0] i_v;
        logic signed [SAMP_W-1:0] q_v;
        logic signed [TRIG_W-1:0] c_v;
        logic signed [TRIG_W-1:0] s_v;
    } cap_t;

    logic [ADDR_W-1:0]        phase_addr;
    logic signed [TRIG_W-1:0] lut_sin;
    logic signed [TRIG_W-1:0] lut_cos;
    logic signed [OUT_W-1:0]  mix_out;
    cap_t                     cap;

    nco_accum #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_nco (
        .clk(clk), .rst(rst), .en(en), .ftw(ftw), .phase_addr(phase_addr)
    );

    sincos_lut #(.ADDR_W(ADDR_W), .AMP_W(TRIG_W)) u_lut (
        .addr(phase_addr), .sin_o(lut_sin), .cos_o(lut_cos)
    );

    // Capture stage: sample and its oscillator values travel together
    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (en) begin
            cap.i_v <= $signed(i_in);
            cap.q_v <= $signed(q_in);
            cap.c_v <= lut_cos;
            cap.s_v <= lut_sin;
        end
    end

    mix_core #(.SAMP_W(SAMP_W), .TRIG_W(TRIG_W), .OUT_W(OUT_W)) u_mix (
        .clk(clk), .rst(rst), .en(en),
        .i_s(cap.i_v), .q_s(cap.q_v), .cos_s(cap.c_v), .sin_s(cap.s_v),
        .mix_out(mix_out)
    );

    assign mod_out = mix_out;

    // R3
    always_ff @(posedge clk) begin
        if (!rst) begin
            quad_circle_chk: assert ((int'(lut_cos) * int'(lut_cos) + int'(lut_sin) * int'(lut_sin)
                                      >= CIRCLE - CIR_TOL) &&
                                     (int'(lut_cos) * int'(lut_cos) + int'(lut_sin) * int'(lut_sin)
                                      <= CIRCLE + CIR_TOL));
        end
    end

    // R7
    out_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(mod_out));

endmodule

// File: tb/quad_upconv_bench.sv
module quad_upconv_bench;
    localparam int CLK_P = 10;
    localparam real TWO_PI = 6.28318530717958647692;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] ftw = '0;
    logic [11:0] i_in = '0;
    logic [11:0] q_in = '0;
    logic [11:0] mod_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] macc = '0;
    int pipe0 = 0, pipe1 = 0, pipe2 = 0;

    quad_upconv u_quad_upconv (
        .clk(clk), .rst(rst), .en(en), .ftw(ftw),
        .i_in(i_in), .q_in(q_in), .mod_out(mod_out)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic int sin_ref(input int a);
        return int'(2047.0 * $sin(TWO_PI * (real'(a) + 0.5) / 1024.0));
    endfunction

    function automatic int cos_ref(input int a);
        return int'(2047.0 * $cos(TWO_PI * (real'(a) + 0.5) / 1024.0));
    endfunction

    function automatic int expect_out(input int iv, input int qv, input int a);
        int e;
        int r;
        e = iv * cos_ref(a) - qv * sin_ref(a);
        r = (e + 1024) >>> 11;
        if (r > 2047) r = 2047;
        if (r < -2048) r = -2048;
        return r;
    endfunction

    task automatic check(input int exp_v, input string req);
        int act;
        act = int'($signed(mod_out));
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: mod_out=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // One cycle: check the output left by the previous edge, drive, advance the model
    task automatic step(input int iv, input int qv, input logic [31:0] f,
                        input logic e, input string req);
        int nv;
        @(negedge clk);
        check(pipe2, req);
        i_in = 12'(iv);
        q_in = 12'(qv);
        ftw  = f;
        en   = e;
        @(posedge clk);
        if (e) begin
            nv    = expect_out(iv, qv, int'(macc[31:22]));
            pipe2 = pipe1;
            pipe1 = pipe0;
            pipe0 = nv;
            macc  = macc + f;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        en   = 1'b1;
        i_in = 12'd1000;
        q_in = 12'd700;
        ftw  = 32'h1234_5678;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
        macc = '0;
        pipe0 = 0; pipe1 = 0; pipe2 = 0;
        // R9: everything cleared
        check(0, "R9");
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R6: impulse latency at a fixed phase
        step(2047, 0, 32'd0, 1'b1, "R6");
        for (int k = 0; k < 4; k++) step(0, 0, 32'd0, 1'b1, "R6");

        // R2 / R3: one address per cycle, full period, each axis alone
        for (int k = 0; k < 1030; k++) step(2047, 0, 32'h0040_0000, 1'b1, "R3");
        for (int k = 0; k < 1030; k++) step(0, -2047, 32'h0040_0000, 1'b1, "R2");

        // R5 / R10: extreme opposite-sign inputs reach both clamps
        for (int k = 0; k < 1030; k++) step(-2048, 2047, 32'h0040_0000, 1'b1, "R5");
        for (int k = 0; k < 300; k++) step(-2048, -2048, 32'h0123_4567, 1'b1, "R10");

        // R4 / R1: random samples, random and near-limit tuning words with wrap
        for (int k = 0; k < 1500; k++)
            step(int'($urandom_range(4095)) - 2048, int'($urandom_range(4095)) - 2048,
                 (k < 750) ? $urandom() : 32'h4CCC_CCCC, 1'b1, (k < 750) ? "R1" : "R4");

        // R8: tuning word changes mid-stream, no phase restart
        for (int k = 0; k < 400; k++)
            step(1500, -900, (k % 40 < 20) ? 32'h0A00_0000 : 32'h0033_0000, 1'b1, "R8");

        // R7: enable gaps while inputs and tuning word keep changing
        for (int k = 0; k < 800; k++)
            step(int'($urandom_range(4095)) - 2048, int'($urandom_range(4095)) - 2048,
                 $urandom(), ($urandom_range(2) != 0), "R7");

        // R9: reset in mid-run, then resume
        do_reset();
        for (int k = 0; k < 200; k++)
            step(int'($urandom_range(4095)) - 2048, 333, 32'h0600_0000, 1'b1, "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule